// File: doc/BRIEF.md
# Shared Reservation Station Pool

This block is a small pool of reservation station slots that serves all four execution units of a core: the integer unit, the floating-point adder, the floating-point multiplier and the floating-point divider. Each of the two insert lanes can place one instruction into a free slot in the same cycle. An instruction carries:

- a unit class and an opcode;
- two operand values, or the reorder-buffer tags of the instructions that will produce them;
- the reorder-buffer position of its own result.

A slot waits until both of its sources are present and its unit reports that it is free. It is then released to that unit, and the slot becomes empty again at that point. The slot is not held while the instruction executes.

While a slot waits, it watches the common data bus. A broadcast whose tag matches one of the slot's pending sources delivers the value into that operand. Upstream logic reads the free-slot count and the per-slot empty flags, and inserts only as many instructions as the pool can hold. When several ready slots compete for one unit, the slot with the oldest reorder-buffer position wins. Age is measured from the current reorder-buffer head, so the choice stays correct when the buffer index wraps around.

Top module: `rs_pool`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every slot is empty, free_count equals NUM_SLOTS, and no iss_valid bit is high.
- R2: Each cycle up to two instructions are accepted. Lane 0 takes the lowest-numbered empty slot. Lane 1 takes the next empty slot above it, or the lowest empty slot when lane 0 is idle. slot_free bit i is 1 exactly when slot i is empty.
- R3: An insert that finds no empty slot left for it is dropped. Lane 1 counts lane 0 first. A dropped insert leaves every stored slot unchanged.
- R4: free_count always equals the number of empty slots.
- R5: Unit codes are 0 integer, 1 FP add, 2 FP multiply and 3 FP divide; bit u of fu_free and iss_valid and field u of each issue bus belong to unit u. iss_valid[u] is high in any cycle where fu_free[u] is high and some slot of class u has both sources present. In that cycle the op, both operands and the destination of the chosen slot appear on field u.
- R6: Among ready slots of one class, the chosen slot has the smallest age, where age is (destination - rob_head) modulo 2^TAG_W. On equal age the lower slot index wins.
- R7: A slot released on iss_valid becomes empty at the clock edge that ends that cycle. A slot freed at an edge cannot be refilled by an insert sampled at that same edge.
- R8: If cdb_valid is high and cdb_tag matches a pending source tag of an occupied slot, the value is captured and the tag is cleared at that edge. The slot can issue from the next cycle.
- R9: An insert whose source tag matches the broadcast in the same cycle stores the broadcast value and is stored with no pending source.
- R10: All four units can each receive one instruction in the same cycle.
- R11: An inserted instruction is first visible on the issue outputs in the cycle after its insert edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rob_head | input | TAG_W | Current oldest reorder-buffer position |
| ins0_valid | input | 1 | Lane 0 insert request |
| ins0_unit | input | 2 | Lane 0 unit class |
| ins0_op | input | OP_W | Lane 0 opcode |
| ins0_vj | input | DATA_W | Lane 0 first operand value |
| ins0_vk | input | DATA_W | Lane 0 second operand value |
| ins0_qj_valid | input | 1 | Lane 0 first source still pending |
| ins0_qj | input | TAG_W | Lane 0 first source producer tag |
| ins0_qk_valid | input | 1 | Lane 0 second source still pending |
| ins0_qk | input | TAG_W | Lane 0 second source producer tag |
| ins0_dest | input | TAG_W | Lane 0 destination ROB position |
| ins1_valid | input | 1 | Lane 1 insert request |
| ins1_unit | input | 2 | Lane 1 unit class |
| ins1_op | input | OP_W | Lane 1 opcode |
| ins1_vj | input | DATA_W | Lane 1 first operand value |
| ins1_vk | input | DATA_W | Lane 1 second operand value |
| ins1_qj_valid | input | 1 | Lane 1 first source still pending |
| ins1_qj | input | TAG_W | Lane 1 first source producer tag |
| ins1_qk_valid | input | 1 | Lane 1 second source still pending |
| ins1_qk | input | TAG_W | Lane 1 second source producer tag |
| ins1_dest | input | TAG_W | Lane 1 destination ROB position |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Broadcast producer tag |
| cdb_value | input | DATA_W | Broadcast value |
| fu_free | input | 4 | Per-unit ready to accept |
| iss_valid | output | 4 | Per-unit issue strobe |
| iss_op | output | 4*OP_W | Per-unit opcode |
| iss_vj | output | 4*DATA_W | Per-unit first operand |
| iss_vk | output | 4*DATA_W | Per-unit second operand |
| iss_dest | output | 4*TAG_W | Per-unit destination ROB position |
| slot_free | output | NUM_SLOTS | Per-slot empty flag |
| free_count | output | $clog2(NUM_SLOTS+1) | Number of empty slots |

## Verification
The issue outputs are combinational from the slot state, rob_head and fu_free. An issue decision is therefore due in the same cycle that fu_free rises. An insert or a bus capture changes the outputs one edge later, and a released slot shows as empty one edge after its issue cycle. The bench drives inputs just after the falling edge. It compares all outputs against its own slot model one time unit later, before the rising edge. It advances the model at the rising edge using the inputs that were sampled there. In this way every comparison falls in the cycle where that result is due, with no edge-ordering race.

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 32,
  parameter int OP_W      = 6,
  parameter int TAG_W     = 3,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TAG_W-1:0]      rob_head,
  input  logic                  ins0_valid,
  input  logic [1:0]            ins0_unit,
  input  logic [OP_W-1:0]       ins0_op,
  input  logic [DATA_W-1:0]     ins0_vj,
  input  logic [DATA_W-1:0]     ins0_vk,
  input  logic                  ins0_qj_valid,
  input  logic [TAG_W-1:0]      ins0_qj,
  input  logic                  ins0_qk_valid,
  input  logic [TAG_W-1:0]      ins0_qk,
  input  logic [TAG_W-1:0]      ins0_dest,
  input  logic                  ins1_valid,
  input  logic [1:0]            ins1_unit,
  input  logic [OP_W-1:0]       ins1_op,
  input  logic [DATA_W-1:0]     ins1_vj,
  input  logic [DATA_W-1:0]     ins1_vk,
  input  logic                  ins1_qj_valid,
  input  logic [TAG_W-1:0]      ins1_qj,
  input  logic                  ins1_qk_valid,
  input  logic [TAG_W-1:0]      ins1_qk,
  input  logic [TAG_W-1:0]      ins1_dest,
  input  logic                  cdb_valid,
  input  logic [TAG_W-1:0]      cdb_tag,
  input  logic [DATA_W-1:0]     cdb_value,
  input  logic [3:0]            fu_free,
  output logic [3:0]            iss_valid,
  output logic [4*OP_W-1:0]     iss_op,
  output logic [4*DATA_W-1:0]   iss_vj,
  output logic [4*DATA_W-1:0]   iss_vk,
  output logic [4*TAG_W-1:0]    iss_dest,
  output logic [NUM_SLOTS-1:0]  slot_free,
  output logic [CNT_W-1:0]      free_count
);

  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int NUM_UNITS = 4;

  logic [NUM_SLOTS-1:0] busy, qj_pend, qk_pend, ready, take;
  logic [1:0]           e_unit [NUM_SLOTS];
  logic [OP_W-1:0]      e_op   [NUM_SLOTS];
  logic [DATA_W-1:0]    e_vj   [NUM_SLOTS];
  logic [DATA_W-1:0]    e_vk   [NUM_SLOTS];
  logic [TAG_W-1:0]     e_qj   [NUM_SLOTS];
  logic [TAG_W-1:0]     e_qk   [NUM_SLOTS];
  logic [TAG_W-1:0]     e_dest [NUM_SLOTS];

  logic [CNT_W-1:0]     nfree;
  logic [SLOT_W-1:0]    first_free, second_free, slot1;
  logic                 put0, put1;
  logic [SLOT_W-1:0]    pick  [NUM_UNITS];
  logic [NUM_UNITS-1:0] found;

  logic hit0j, hit0k, hit1j, hit1k;
  assign hit0j = cdb_valid && ins0_qj_valid && ins0_qj == cdb_tag;
  assign hit0k = cdb_valid && ins0_qk_valid && ins0_qk == cdb_tag;
  assign hit1j = cdb_valid && ins1_qj_valid && ins1_qj == cdb_tag;
  assign hit1k = cdb_valid && ins1_qk_valid && ins1_qk == cdb_tag;

  assign ready      = busy & ~qj_pend & ~qk_pend;
  assign slot_free  = ~busy;
  assign free_count = nfree;

  always_comb begin
    nfree       = '0;
    first_free  = '0;
    second_free = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!busy[i]) begin
        if (nfree == CNT_W'(0))      first_free  = SLOT_W'(i);
        else if (nfree == CNT_W'(1)) second_free = SLOT_W'(i);
        nfree = nfree + CNT_W'(1);
      end
    end
  end

  assign put0  = ins0_valid && nfree != CNT_W'(0);
  assign slot1 = ins0_valid ? second_free : first_free;
  assign put1  = ins1_valid && (ins0_valid ? nfree > CNT_W'(1) : nfree != CNT_W'(0));

  always_comb begin
    logic [TAG_W-1:0] age;
    logic [TAG_W-1:0] best;
    take = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      found[u] = 1'b0;
      pick[u]  = '0;
      best     = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        age = e_dest[i] - rob_head;
        if (ready[i] && e_unit[i] == 2'(u) && (!found[u] || age < best)) begin
          found[u] = 1'b1;
          best     = age;
          pick[u]  = SLOT_W'(i);
        end
      end
      if (found[u] && fu_free[u]) take[pick[u]] = 1'b1;
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_port
    assign iss_valid[u]                  = found[u] && fu_free[u];
    assign iss_op[u*OP_W +: OP_W]        = e_op[pick[u]];
    assign iss_vj[u*DATA_W +: DATA_W]    = e_vj[pick[u]];
    assign iss_vk[u*DATA_W +: DATA_W]    = e_vk[pick[u]];
    assign iss_dest[u*TAG_W +: TAG_W]    = e_dest[pick[u]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= '0;
      qj_pend <= '0;
      qk_pend <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (take[i]) busy[i] <= 1'b0;
        if (busy[i] && cdb_valid) begin
          if (qj_pend[i] && e_qj[i] == cdb_tag) begin
            e_vj[i]    <= cdb_value;
            qj_pend[i] <= 1'b0;
          end
          if (qk_pend[i] && e_qk[i] == cdb_tag) begin
            e_vk[i]    <= cdb_value;
            qk_pend[i] <= 1'b0;
          end
        end
        if (put0 && first_free == SLOT_W'(i)) begin
          busy[i]    <= 1'b1;
          e_unit[i]  <= ins0_unit;
          e_op[i]    <= ins0_op;
          e_dest[i]  <= ins0_dest;
          e_qj[i]    <= ins0_qj;
          e_qk[i]    <= ins0_qk;
          e_vj[i]    <= hit0j ? cdb_value : ins0_vj;
          e_vk[i]    <= hit0k ? cdb_value : ins0_vk;
          qj_pend[i] <= ins0_qj_valid && !hit0j;
          qk_pend[i] <= ins0_qk_valid && !hit0k;
        end else if (put1 && slot1 == SLOT_W'(i)) begin
          busy[i]    <= 1'b1;
          e_unit[i]  <= ins1_unit;
          e_op[i]    <= ins1_op;
          e_dest[i]  <= ins1_dest;
          e_qj[i]    <= ins1_qj;
          e_qk[i]    <= ins1_qk;
          e_vj[i]    <= hit1j ? cdb_value : ins1_vj;
          e_vk[i]    <= hit1k ? cdb_value : ins1_vk;
          qj_pend[i] <= ins1_qj_valid && !hit1j;
          qk_pend[i] <= ins1_qk_valid && !hit1k;
        end
      end
    end
  end

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int NUM_SLOTS = 4,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ins0_valid,
  input logic                 ins1_valid,
  input logic [3:0]           fu_free,
  input logic [3:0]           iss_valid,
  input logic [NUM_SLOTS-1:0] slot_free,
  input logic [CNT_W-1:0]     free_count
);

  p_reset_empty_r1: assert property (@(posedge clk)
    !rst_n |=> (free_count == CNT_W'(NUM_SLOTS) && iss_valid == 4'b0));

  p_issue_needs_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid & ~fu_free) == 4'b0);

  p_count_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    free_count == CNT_W'($countones(slot_free)));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (free_count == '0 && iss_valid == 4'b0) |=> $stable(slot_free));

  p_no_insert_no_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins0_valid && !ins1_valid) |=> free_count >= $past(free_count));

  p_issue_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid != 4'b0 && !ins0_valid && !ins1_valid) |=> free_count > $past(free_count));

endmodule

bind rs_pool rs_pool_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins0_valid(ins0_valid), .ins1_valid(ins1_valid),
  .fu_free(fu_free), .iss_valid(iss_valid), .slot_free(slot_free),
  .free_count(free_count)
);

// File: tb/rs_pool_tb.sv
module rs_pool_tb;
  localparam int NS = 4, DW = 32, OW = 6, TW = 3, CW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [TW-1:0] rob_head;
  logic ins0_valid, ins0_qj_valid, ins0_qk_valid;
  logic [1:0] ins0_unit; logic [OW-1:0] ins0_op; logic [DW-1:0] ins0_vj, ins0_vk;
  logic [TW-1:0] ins0_qj, ins0_qk, ins0_dest;
  logic ins1_valid, ins1_qj_valid, ins1_qk_valid;
  logic [1:0] ins1_unit; logic [OW-1:0] ins1_op; logic [DW-1:0] ins1_vj, ins1_vk;
  logic [TW-1:0] ins1_qj, ins1_qk, ins1_dest;
  logic cdb_valid; logic [TW-1:0] cdb_tag; logic [DW-1:0] cdb_value;
  logic [3:0] fu_free, iss_valid;
  logic [4*OW-1:0] iss_op; logic [4*DW-1:0] iss_vj, iss_vk; logic [4*TW-1:0] iss_dest;
  logic [NS-1:0] slot_free; logic [CW-1:0] free_count;

  rs_pool #(.NUM_SLOTS(NS), .DATA_W(DW), .OP_W(OW), .TAG_W(TW)) u_dut (.*);

  int checks = 0, fails = 0;

  bit            mb [NS];
  logic [1:0]    mu [NS];
  logic [OW-1:0] mo [NS];
  logic [DW-1:0] mvj[NS], mvk[NS];
  bit            mpj[NS], mpk[NS];
  logic [TW-1:0] mqj[NS], mqk[NS], md[NS];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int count_free();
    int c = 0;
    for (int i = 0; i < NS; i++) if (!mb[i]) c++;
    return c;
  endfunction

  task automatic clear_in();
    ins0_valid = 0; ins1_valid = 0; cdb_valid = 0; fu_free = 4'h0;
    ins0_qj_valid = 0; ins0_qk_valid = 0; ins1_qj_valid = 0; ins1_qk_valid = 0;
    ins0_unit = 0; ins0_op = 0; ins0_vj = 0; ins0_vk = 0; ins0_qj = 0; ins0_qk = 0; ins0_dest = 0;
    ins1_unit = 0; ins1_op = 0; ins1_vj = 0; ins1_vk = 0; ins1_qj = 0; ins1_qk = 0; ins1_dest = 0;
    cdb_tag = 0; cdb_value = 0;
  endtask

  task automatic load(int s, logic [1:0] u, logic [OW-1:0] o, logic [DW-1:0] vj, logic [DW-1:0] vk,
                      bit pj, logic [TW-1:0] qj, bit pk, logic [TW-1:0] qk, logic [TW-1:0] d);
    bit hj, hk;
    hj = cdb_valid && pj && qj == cdb_tag;
    hk = cdb_valid && pk && qk == cdb_tag;
    mb[s] = 1; mu[s] = u; mo[s] = o; md[s] = d; mqj[s] = qj; mqk[s] = qk;
    mvj[s] = hj ? cdb_value : vj; mvk[s] = hk ? cdb_value : vk;
    mpj[s] = pj && !hj; mpk[s] = pk && !hk;
  endtask

  // Inputs are set after a falling edge; this checks, crosses one rising edge, updates the model.
  task automatic step();
    logic [NS-1:0] sf;
    bit hit[4]; int pk[4]; logic [TW-1:0] age, best;
    int nf, f0, f1, s1; bit p0, p1;
    #1;
    nf = count_free();
    chk("R4", "free_count", 64'(free_count), 64'(nf));
    for (int i = 0; i < NS; i++) sf[i] = !mb[i];
    chk("R2 R3 R7", "slot_free", 64'(slot_free), 64'(sf));
    for (int u = 0; u < 4; u++) begin
      hit[u] = 0; pk[u] = 0; best = 0;
      for (int i = 0; i < NS; i++) begin
        age = md[i] - rob_head;
        if (mb[i] && !mpj[i] && !mpk[i] && mu[i] == 2'(u) && (!hit[u] || age < best)) begin
          hit[u] = 1; best = age; pk[u] = i;
        end
      end
      chk("R5 R10 R11", "iss_valid", 64'(iss_valid[u]), 64'(hit[u] && fu_free[u]));
      if (hit[u] && fu_free[u]) begin
        chk("R6", "iss_dest", 64'(iss_dest[u*TW +: TW]), 64'(md[pk[u]]));
        chk("R5", "iss_op", 64'(iss_op[u*OW +: OW]), 64'(mo[pk[u]]));
        chk("R8 R9", "iss_vj", 64'(iss_vj[u*DW +: DW]), 64'(mvj[pk[u]]));
        chk("R8 R9", "iss_vk", 64'(iss_vk[u*DW +: DW]), 64'(mvk[pk[u]]));
      end
    end
    f0 = -1; f1 = -1;
    for (int i = 0; i < NS; i++) if (!mb[i]) begin
      if (f0 < 0) f0 = i; else if (f1 < 0) f1 = i;
    end
    p0 = ins0_valid && nf >= 1;
    p1 = ins1_valid && (ins0_valid ? nf >= 2 : nf >= 1);
    s1 = ins0_valid ? f1 : f0;
    @(posedge clk);
    for (int u = 0; u < 4; u++) if (hit[u] && fu_free[u]) mb[pk[u]] = 0;
    for (int i = 0; i < NS; i++) if (mb[i] && cdb_valid) begin
      if (mpj[i] && mqj[i] == cdb_tag) begin mvj[i] = cdb_value; mpj[i] = 0; end
      if (mpk[i] && mqk[i] == cdb_tag) begin mvk[i] = cdb_value; mpk[i] = 0; end
    end
    if (p0) load(f0, ins0_unit, ins0_op, ins0_vj, ins0_vk, ins0_qj_valid, ins0_qj, ins0_qk_valid, ins0_qk, ins0_dest);
    if (p1) load(s1, ins1_unit, ins1_op, ins1_vj, ins1_vk, ins1_qj_valid, ins1_qj, ins1_qk_valid, ins1_qk, ins1_dest);
    @(negedge clk);
  endtask

  task automatic randomize_in();
    ins0_valid = ($urandom % 10) < 6; ins1_valid = ($urandom % 10) < 5;
    ins0_unit = 2'($urandom); ins0_op = OW'($urandom); ins0_vj = $urandom; ins0_vk = $urandom;
    ins0_qj_valid = ($urandom % 10) < 4; ins0_qk_valid = ($urandom % 10) < 4;
    ins0_qj = TW'($urandom); ins0_qk = TW'($urandom); ins0_dest = TW'($urandom);
    ins1_unit = 2'($urandom); ins1_op = OW'($urandom); ins1_vj = $urandom; ins1_vk = $urandom;
    ins1_qj_valid = ($urandom % 10) < 4; ins1_qk_valid = ($urandom % 10) < 4;
    ins1_qj = TW'($urandom); ins1_qk = TW'($urandom); ins1_dest = TW'($urandom);
    cdb_valid = $urandom % 2; cdb_tag = TW'($urandom); cdb_value = $urandom;
    fu_free = 4'($urandom);
    if ($urandom % 8 == 0) rob_head = TW'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NS; i++) begin mb[i] = 0; mpj[i] = 0; mpk[i] = 0; end
    clear_in();
    rob_head = 0;
    rst_n = 0;
    fu_free = 4'hF; ins0_valid = 1; ins1_valid = 1;
    repeat (3) @(negedge clk);
    #1;
    // R1: empty while in reset
    chk("R1", "free_count in reset", 64'(free_count), 64'(NS));
    chk("R1", "iss_valid in reset", 64'(iss_valid), 64'(0));
    @(negedge clk);
    clear_in();
    rst_n = 1;
    step();

    // R3, R8: fill with blocked entries, overfill, then wake all by one broadcast
    ins0_valid = 1; ins0_unit = 1; ins0_dest = 1; ins0_qj_valid = 1; ins0_qj = 5; ins0_vk = 32'h11;
    ins1_valid = 1; ins1_unit = 1; ins1_dest = 2; ins1_qj_valid = 1; ins1_qj = 5; ins1_vk = 32'h22;
    step();
    ins0_unit = 2; ins0_dest = 3; ins0_qj_valid = 0; ins0_qk_valid = 1; ins0_qk = 5;
    ins1_unit = 3; ins1_dest = 4;
    step();
    ins0_unit = 0; ins0_dest = 5; ins0_qj_valid = 0; ins0_qk_valid = 0;
    ins1_unit = 0; ins1_dest = 6; ins1_qj_valid = 0;
    step();
    chk("R3", "full pool ignores inserts", 64'(free_count), 64'(0));
    clear_in(); cdb_valid = 1; cdb_tag = 5; cdb_value = 32'hABCD;
    step();
    clear_in(); fu_free = 4'hF;  // R10: three units issue together
    step(); step(); step();

    // R6: oldest first across a wrapped ROB index
    clear_in(); rob_head = 6;
    ins0_valid = 1; ins0_unit = 2; ins0_dest = 1; ins1_valid = 1; ins1_unit = 2; ins1_dest = 7;
    step();
    clear_in(); ins0_valid = 1; ins0_unit = 2; ins0_dest = 6;
    step();
    clear_in(); fu_free = 4'b0100;
    step(); step(); step(); step();

    // R9: capture at insert time
    clear_in(); rob_head = 0;
    cdb_valid = 1; cdb_tag = 3; cdb_value = 32'h5A5A;
    ins0_valid = 1; ins0_unit = 0; ins0_dest = 2; ins0_qj_valid = 1; ins0_qj = 3; ins0_vk = 32'h7;
    step();
    clear_in(); fu_free = 4'b0001;
    step(); step();

    for (int n = 0; n < 4000; n++) begin
      randomize_in();
      step();
    end
    clear_in(); cdb_valid = 1;
    for (int n = 0; n < 64; n++) begin
      cdb_tag = TW'(n); cdb_value = 32'(n * 3); fu_free = 4'hF;
      step();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule